// File: doc/BRIEF.md
# Dual-Port MAC Host Register Bridge

This block sits between a simple processor register bus and a two-port Ethernet MAC. Each bus access carries an address. The block decodes that address into one of three regions: the register bank of port 0, the register bank of port 1, or a small set of local host-interface registers. It answers every access one cycle later with an acknowledge and, for a read, the data. Addresses that fall outside these three regions are reserved.

Each port bank holds the following:
- six configuration words, kept as plain storage;
- a read-only interface status word, driven from outside the block;
- a 48-bit unicast address split over two words;
- an indirect window onto a small table of multicast addresses.

The block marks every finished port access in a per-port ready flag. When that port's enable bit is set, the same access also latches a per-port interrupt status bit. The interrupt line is the registered OR of all enabled status bits. Software clears both the ready flags and the status bits by writing 1 to them.

Top module: `host_reg_bridge`

## Requirements
- R1: A request (`req_i` high at a rising edge) is acknowledged by `ack_o` high after that edge, for one cycle per request. For a read, `rdata_o` carries the data in the same cycle as the acknowledge.
- R2: The port 0 bank spans 0x200–0x39F and the port 1 bank spans 0x600–0x79F, at the same offsets plus 0x400. The configuration words sit at bank offsets 0x200, 0x240, 0x280, 0x2C0, 0x300 and 0x340. They reset to 0 and read back what was written, separately for each port.
- R3: Bank offset 0x320 reads the port's `ifc_stat_i` word. Writes to it are ignored.
- R4: Bank offset 0x380 holds unicast bits [31:0]. Bank offset 0x384 stores unicast bits [47:32] from write-data bits [15:0], and its bits [31:16] read as zero.
- R5: Bank offset 0x388 is the multicast data-low word. A write to bank offset 0x38C with bit 23 (read flag) clear stores {wdata[15:0], data-low word} into the table entry chosen by bits [17:16].
- R6: A write to 0x38C with bit 23 set loads the chosen entry into the data-low word and into the data-high field. Offset 0x38C reads as {8'h00, flag, 5'b0, index[1:0], data-high[15:0]}.
- R7: Any other address is reserved. Writes to it are ignored and reads return zero. Reserved addresses include 0x000–0x1FF, 0x3AC–0x3FF, 0x400–0x5FF and 0x7A0–0x7FF. A reserved access sets no ready or status bit.
- R8: Each access to port p's bank sets ready bit p. The ready bits read at host address 0x3A8 (bit p) and drive `rdy_o`.
- R9: Interrupt status sits at 0x3A0 and interrupt enable at 0x3A4, with bit p belonging to port p. A port access sets status bit p only while enable bit p is 1.
- R10: An access to a host-interface address (0x3A0–0x3FF) never sets a ready or status bit.
- R11: Writing 1 to a bit at 0x3A0 or 0x3A8 clears that bit. Writing 0 leaves it unchanged.
- R12: `irq_o` is 1 exactly one cycle after some status bit and its enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Access request, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | 32 | Write data |
| ifc_stat_i | input | NPORT*32 | Interface status word per port (port p at bits [32p+31:32p]) |
| ack_o | output | 1 | Access acknowledge |
| rdata_o | output | 32 | Read data, valid with ack_o |
| rdy_o | output | NPORT | Per-port ready flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: two ports, a four-entry multicast table and an 11-bit address. With two ports, the mirrored port 1 bank, the per-port independence of storage and the gating of each status bit by its own enable can all be exercised. The four-entry table lets all four index values of the indirect window be used, and lets the bench write to one entry and read back a different one.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

   typedef enum logic [1:0] {
      RGN_NONE = 2'd0,
      RGN_MAC  = 2'd1,
      RGN_HOST = 2'd2
   } rgn_e;

   typedef struct packed {
      rgn_e       rgn;
      logic       port;
      logic [9:0] off;
   } dec_t;

   localparam int unsigned DW       = 32;
   localparam int unsigned CFG_N    = 6;
   localparam logic [9:0]  BANK_LO  = 10'h200;
   localparam logic [9:0]  BANK_HI  = 10'h39F;
   localparam logic [9:0]  HOST_LO  = 10'h3A0;
   localparam logic [9:0]  OFF_IFC  = 10'h320;
   localparam logic [9:0]  OFF_UC0  = 10'h380;
   localparam logic [9:0]  OFF_UC1  = 10'h384;
   localparam logic [9:0]  OFF_MC0  = 10'h388;
   localparam logic [9:0]  OFF_MC1  = 10'h38C;
   localparam logic [9:0]  OFF_IST  = 10'h3A0;
   localparam logic [9:0]  OFF_IEN  = 10'h3A4;
   localparam logic [9:0]  OFF_RDY  = 10'h3A8;
   localparam int unsigned MC_FLAG  = 23;

endpackage

// File: rtl/hrb_decode.sv
module hrb_decode
   import hrb_pkg::*;
#(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned NPORT  = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   output dec_t              dec_o
);

   logic upper_zero;
   logic [9:0] off;
   logic port;

   generate
      if (ADDR_W > 11) begin : g_wide
         assign upper_zero = ~|addr_i[ADDR_W-1:11];
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign off  = addr_i[9:0];
   assign port = addr_i[10];

   always_comb begin
      dec_o.off  = off;
      dec_o.port = port;
      dec_o.rgn  = RGN_NONE;
      if (upper_zero && off >= BANK_LO && off <= BANK_HI && (int'(port) < int'(NPORT)))
         dec_o.rgn = RGN_MAC;
      else if (upper_zero && !port && off >= HOST_LO)
         dec_o.rgn = RGN_HOST;
   end

endmodule

// File: rtl/hrb_port_regs.sv
module hrb_port_regs
   import hrb_pkg::*;
#(
   parameter int unsigned MC_DEPTH = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_i,
   input  logic          wr_i,
   input  logic [9:0]    off_i,
   input  logic [DW-1:0] wdata_i,
   input  logic [DW-1:0] ifc_stat_i,
   output logic [DW-1:0] rdata_o
);

   logic [DW-1:0] cfg_q [CFG_N];
   logic [DW-1:0] uc_lo_q;
   logic [15:0]   uc_hi_q;
   logic [DW-1:0] mc_lo_q;
   logic [15:0]   mc_hi_q;
   logic [1:0]    mc_idx_q;
   logic          mc_flag_q;
   logic [47:0]   mc_tab [MC_DEPTH];
   logic [47:0]   tab_rd;
   logic          cfg_hit;
   logic [3:0]    cfg_sel;
   logic          wr_en;

   assign wr_en   = acc_i && wr_i;
   assign cfg_hit = (off_i[5:0] == 6'd0) && (off_i[9:6] >= 4'h8) && (off_i[9:6] <= 4'hD);
   assign cfg_sel = off_i[9:6] - 4'h8;

   generate
      for (genvar c = 0; c < CFG_N; c++) begin : g_cfg
         always_ff @(posedge clk) begin
            if (!rst_n)
               cfg_q[c] <= '0;
            else if (wr_en && cfg_hit && cfg_sel == 4'(c))
               cfg_q[c] <= wdata_i;
         end
      end
      for (genvar e = 0; e < MC_DEPTH; e++) begin : g_tab
         always_ff @(posedge clk) begin
            if (!rst_n)
               mc_tab[e] <= '0;
            else if (wr_en && off_i == OFF_MC1 && !wdata_i[MC_FLAG] && wdata_i[17:16] == 2'(e))
               mc_tab[e] <= {wdata_i[15:0], mc_lo_q};
         end
      end
   endgenerate

   always_comb begin
      tab_rd = '0;
      for (int e = 0; e < MC_DEPTH; e++)
         if (wdata_i[17:16] == 2'(e)) tab_rd = mc_tab[e];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         uc_lo_q   <= '0;
         uc_hi_q   <= '0;
         mc_lo_q   <= '0;
         mc_hi_q   <= '0;
         mc_idx_q  <= '0;
         mc_flag_q <= 1'b0;
      end else if (wr_en) begin
         case (off_i)
            OFF_UC0: uc_lo_q <= wdata_i;
            OFF_UC1: uc_hi_q <= wdata_i[15:0];
            OFF_MC0: mc_lo_q <= wdata_i;
            OFF_MC1: begin
               mc_flag_q <= wdata_i[MC_FLAG];
               mc_idx_q  <= wdata_i[17:16];
               if (wdata_i[MC_FLAG]) begin
                  mc_lo_q <= tab_rd[31:0];
                  mc_hi_q <= tab_rd[47:32];
               end else begin
                  mc_hi_q <= wdata_i[15:0];
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata_o = '0;
      if (cfg_hit)
         rdata_o = cfg_q[cfg_sel[2:0]];
      else begin
         case (off_i)
            OFF_IFC: rdata_o = ifc_stat_i;
            OFF_UC0: rdata_o = uc_lo_q;
            OFF_UC1: rdata_o = {16'h0, uc_hi_q};
            OFF_MC0: rdata_o = mc_lo_q;
            OFF_MC1: rdata_o = {8'h00, mc_flag_q, 5'b0, mc_idx_q, mc_hi_q};
            default: rdata_o = '0;
         endcase
      end
   end

   // R5: a store through the window keeps the written upper half visible
   assert_mc_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off_i == OFF_MC1 && !wdata_i[MC_FLAG]) |=> (mc_hi_q == $past(wdata_i[15:0])));

endmodule

// File: rtl/hrb_irq.sv
module hrb_irq
   import hrb_pkg::*;
#(
   parameter int unsigned NPORT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] done_i,
   input  logic             host_wr_i,
   input  logic [9:0]       off_i,
   input  logic [NPORT-1:0] wbits_i,
   output logic [NPORT-1:0] ist_o,
   output logic [NPORT-1:0] ien_o,
   output logic [NPORT-1:0] rdy_o,
   output logic             irq_o
);

   logic [NPORT-1:0] ist_q, ien_q, rdy_q;
   logic [NPORT-1:0] ist_clr, rdy_clr;
   logic             irq_q;

   assign ist_clr = (host_wr_i && off_i == OFF_IST) ? wbits_i : '0;
   assign rdy_clr = (host_wr_i && off_i == OFF_RDY) ? wbits_i : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ist_q <= '0;
         ien_q <= '0;
         rdy_q <= '0;
         irq_q <= 1'b0;
      end else begin
         if (host_wr_i && off_i == OFF_IEN)
            ien_q <= wbits_i;
         ist_q <= (ist_q & ~ist_clr) | (done_i & ien_q);
         rdy_q <= (rdy_q & ~rdy_clr) | done_i;
         irq_q <= |(ist_q & ien_q);
      end
   end

   assign ist_o = ist_q;
   assign ien_o = ien_q;
   assign rdy_o = rdy_q;
   assign irq_o = irq_q;

   // R10: without a port completion no ready bit rises
   assert_host_no_rdy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i == '0) |=> ((rdy_q & ~$past(rdy_q)) == '0));

   // R9: a status bit never rises while its enable was clear
   assert_gated_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((ist_q & ~$past(ist_q) & ~$past(ien_q)) == '0));

   // R12: the line is only raised after some status bit was set
   assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(ist_q) != '0));

endmodule

// File: rtl/host_reg_bridge.sv
module host_reg_bridge
   import hrb_pkg::*;
#(
   parameter int unsigned ADDR_W   = 11,
   parameter int unsigned NPORT    = 2,
   parameter int unsigned MC_DEPTH = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_i,
   input  logic                wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [31:0]         wdata_i,
   input  logic [NPORT*32-1:0] ifc_stat_i,
   output logic                ack_o,
   output logic [31:0]         rdata_o,
   output logic [NPORT-1:0]    rdy_o,
   output logic                irq_o
);

   generate
      if (ADDR_W < 11) begin : g_bad_addr
         $error("host_reg_bridge: ADDR_W must be at least 11");
      end
      if (NPORT < 1 || NPORT > 2) begin : g_bad_port
         $error("host_reg_bridge: NPORT must be 1 or 2");
      end
      if (MC_DEPTH < 1 || MC_DEPTH > 4) begin : g_bad_depth
         $error("host_reg_bridge: MC_DEPTH must be 1 to 4");
      end
   endgenerate

   dec_t             dec;
   logic [NPORT-1:0] done;
   logic [DW-1:0]    port_rd [NPORT];
   logic [NPORT-1:0] ist, ien, rdy;
   logic             host_wr;
   logic [DW-1:0]    rd_mux;
   logic [DW-1:0]    rdata_q;
   logic             ack_q;

   hrb_decode #(.ADDR_W(ADDR_W), .NPORT(NPORT)) i_dec (
      .addr_i (addr_i),
      .dec_o  (dec)
   );

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         assign done[p] = req_i && dec.rgn == RGN_MAC && int'(dec.port) == p;
         hrb_port_regs #(.MC_DEPTH(MC_DEPTH)) i_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .acc_i      (done[p]),
            .wr_i       (wr_i),
            .off_i      (dec.off),
            .wdata_i    (wdata_i),
            .ifc_stat_i (ifc_stat_i[p*32 +: 32]),
            .rdata_o    (port_rd[p])
         );
      end
   endgenerate

   assign host_wr = req_i && wr_i && dec.rgn == RGN_HOST;

   hrb_irq #(.NPORT(NPORT)) i_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (done),
      .host_wr_i (host_wr),
      .off_i     (dec.off),
      .wbits_i   (wdata_i[NPORT-1:0]),
      .ist_o     (ist),
      .ien_o     (ien),
      .rdy_o     (rdy),
      .irq_o     (irq_o)
   );

   always_comb begin
      rd_mux = '0;
      case (dec.rgn)
         RGN_MAC: begin
            for (int p = 0; p < NPORT; p++)
               if (int'(dec.port) == p) rd_mux = port_rd[p];
         end
         RGN_HOST: begin
            case (dec.off)
               OFF_IST: rd_mux = 32'(ist);
               OFF_IEN: rd_mux = 32'(ien);
               OFF_RDY: rd_mux = 32'(rdy);
               default: rd_mux = '0;
            endcase
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q   <= 1'b0;
         rdata_q <= '0;
      end else begin
         ack_q   <= req_i;
         rdata_q <= (req_i && !wr_i) ? rd_mux : '0;
      end
   end

   assign ack_o   = ack_q;
   assign rdata_o = rdata_q;
   assign rdy_o   = rdy;

   // R1: every request is answered in the following cycle, and only then
   assert_ack_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> ack_o);
   assert_no_spurious_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !ack_o);

   // R7: reserved reads return zero
   assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !wr_i && dec.rgn == RGN_NONE) |=> (rdata_o == '0));

endmodule

// File: tb/test_host_reg_bridge.sv
module test_host_reg_bridge;

   localparam int unsigned ADDR_W = 11;
   localparam int unsigned NPORT  = 2;
   localparam logic [31:0] IFC0 = 32'hA5A5_0001;
   localparam logic [31:0] IFC1 = 32'h5A5A_0002;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0;
   logic wr = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [NPORT*32-1:0] ifc_stat;
   logic ack;
   logic [31:0] rdata;
   logic [NPORT-1:0] rdy;
   logic irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   typedef struct {
      bit          chk;
      logic [31:0] exp;
      string       tag;
   } item_t;
   item_t sb[$];

   assign ifc_stat = {IFC1, IFC0};

   always #4 clk = ~clk;

   host_reg_bridge #(.ADDR_W(ADDR_W), .NPORT(NPORT), .MC_DEPTH(4)) i_host_reg_bridge (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req),
      .wr_i       (wr),
      .addr_i     (addr),
      .wdata_i    (wdata),
      .ifc_stat_i (ifc_stat),
      .ack_o      (ack),
      .rdata_o    (rdata),
      .rdy_o      (rdy),
      .irq_o      (irq)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus(bit w, logic [ADDR_W-1:0] a, logic [31:0] d, bit chk, logic [31:0] e, string tag);
      item_t it;
      @(negedge clk);
      req = 1'b1; wr = w; addr = a; wdata = d;
      it.chk = chk; it.exp = e; it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      req = 1'b0; wr = 1'b0;
   endtask

   task automatic wr_reg(logic [ADDR_W-1:0] a, logic [31:0] d);
      bus(1'b1, a, d, 1'b0, '0, "");
   endtask

   task automatic rd_reg(logic [ADDR_W-1:0] a, logic [31:0] e, string tag);
      bus(1'b0, a, '0, 1'b1, e, tag);
   endtask

   // monitor: pops the scoreboard on every acknowledge
   always @(negedge clk) begin
      if (rst_n && ack) begin
         if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R1 unexpected ack actual=1 expected=0");
         end else begin
            item_t it;
            it = sb.pop_front();
            if (it.chk) check(it.tag, rdata, it.exp);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset ack", 32'(ack), 0);
      check("R8 reset rdy", 32'(rdy), 0);
      check("R12 reset irq", 32'(irq), 0);
      rst_n = 1'b1;
      rd_reg(11'h3A4, 0, "R9 enable reset");

      wr_reg(11'h240, 32'h1111_0001);
      wr_reg(11'h640, 32'h2222_0002);
      rd_reg(11'h240, 32'h1111_0001, "R2 p0 cfg");
      rd_reg(11'h640, 32'h2222_0002, "R2 p1 cfg");
      rd_reg(11'h200, 0, "R2 p0 other cfg");
      rd_reg(11'h600, 0, "R2 p1 other cfg");

      wr_reg(11'h320, 32'hFFFF_FFFF);
      rd_reg(11'h320, IFC0, "R3 p0 ifc");
      rd_reg(11'h720, IFC1, "R3 p1 ifc");

      wr_reg(11'h384, 32'hFFFF_BEEF);
      rd_reg(11'h384, 32'h0000_BEEF, "R4 uc hi");
      wr_reg(11'h380, 32'h0102_0304);
      rd_reg(11'h380, 32'h0102_0304, "R4 uc lo");

      wr_reg(11'h388, 32'hCAFE_0002);
      wr_reg(11'h38C, 32'h0002_1234);
      wr_reg(11'h388, 32'hDEAD_0001);
      wr_reg(11'h38C, 32'h0001_5678);
      wr_reg(11'h388, 32'h0);
      wr_reg(11'h38C, 32'h0082_0000);
      rd_reg(11'h388, 32'hCAFE_0002, "R6 entry2 lo");
      rd_reg(11'h38C, 32'h0082_1234, "R5 R6 entry2 word1");
      wr_reg(11'h38C, 32'h0081_0000);
      rd_reg(11'h388, 32'hDEAD_0001, "R5 entry1 lo");
      wr_reg(11'h78C, 32'h0082_0000);
      rd_reg(11'h788, 0, "R2 p1 table separate");

      wr_reg(11'h100, 32'hFFFF_FFFF);
      rd_reg(11'h100, 0, "R7 low reserved");
      rd_reg(11'h7A4, 0, "R7 p1 host mirror");
      rd_reg(11'h3AC, 0, "R7 host reserved");

      rd_reg(11'h3A8, 32'h3, "R8 ready bits");
      check("R8 rdy_o", 32'(rdy), 3);
      wr_reg(11'h3A8, 32'h1);
      rd_reg(11'h3A8, 32'h2, "R11 rdy w1c");
      wr_reg(11'h3A8, 32'h2);
      rd_reg(11'h100, 0, "R7 reserved read");
      check("R7 reserved no rdy", 32'(rdy), 0);
      rd_reg(11'h3A0, 0, "R9 status while disabled");
      check("R10 host no rdy", 32'(rdy), 0);

      wr_reg(11'h3A4, 32'h1);
      rd_reg(11'h3A4, 32'h1, "R9 enable readback");
      rd_reg(11'h640, 32'h2222_0002, "R2 p1 cfg again");
      rd_reg(11'h3A0, 0, "R9 p1 disabled");
      check("R8 p1 rdy", 32'(rdy), 2);
      rd_reg(11'h240, 32'h1111_0001, "R2 p0 cfg again");
      check("R12 irq not yet", 32'(irq), 0);
      @(negedge clk);
      check("R12 irq raised", 32'(irq), 1);
      rd_reg(11'h3A0, 32'h1, "R9 p0 status");
      wr_reg(11'h3A0, 32'h1);
      rd_reg(11'h3A0, 0, "R11 status w1c");
      check("R12 irq cleared", 32'(irq), 0);

      wr_reg(11'h3A4, 32'h2);
      rd_reg(11'h600, 0, "R2 p1 cfg zero");
      @(negedge clk);
      check("R12 irq p1", 32'(irq), 1);
      wr_reg(11'h3A4, 32'h0);
      @(negedge clk);
      check("R12 irq gated", 32'(irq), 0);
      rd_reg(11'h3A0, 32'h2, "R10 status kept");

      repeat (3) @(negedge clk);
      check("R1 all acks seen", 32'(sb.size()), 0);
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule